// File: doc/BRIEF.md
# Blanking-Aligned Debounced Sense Sampler

This block takes two readings of a comparator sense bit for each request. Each reading is lined up with one full horizontal blanking interval. After a start strobe, the block waits until the display timing is outside blanking, then waits for blanking to begin and to end again. It settles for a fixed delay and takes a baseline read. It then takes confirming reads, spaced by the same delay, until one of them matches the baseline.

When a confirming read disagrees with the baseline, the block reads the sense bit again on the very next clock. If that second read agrees with the disagreeing one, it becomes the new baseline and confirmation goes on. If too many confirmation attempts fail, the reading is reported low. The sense bit is active-low: a low result means the comparator threshold was crossed.

Each of the three blanking waits has its own timeout. This guards against a timing generator that has stopped. When any wait expires, the request ends at once with an error. All delays are counted in ticks from an external tick strobe. The tick period and the delay lengths are parameters.

Top module: `hblank_sense_sampler`

## Requirements
- R1: After reset, `result_o` is 0, `done_o` is 0 and `err_o` is 0.
- R2: A reading waits for `hblank` to be low, then high, then low again, and then settles. The first reading is stored in `result_o` bit 0 and the second in bit 1. When the first reading ends during the low phase of blanking, the second reading uses the next blanking interval.
- R3: When the sense bit is steady, each result bit equals the sense level.
- R4: A confirming read that differs from the baseline, followed on the next clock by an equal read, replaces the baseline. The reading then settles on the new level once a later confirming read matches it.
- R5: After MAX_ATTEMPTS confirming reads that all fail to match, the reading is reported as 0.
- R6: Each of the three blanking waits ends the request after TIMEOUT_NS/TICK_NS ticks without the awaited level. The request then finishes with `done_o`=1, `err_o`=1 and `result_o`=0.
- R7: Timers advance only on clock cycles where `tick` is 1. With `tick` held at 0, no timeout ever fires.
- R8: `done_o` is high for exactly one cycle. In that cycle `result_o` and `err_o` are valid, and both hold until the next request is accepted.
- R9: `start` is ignored while a request is in progress. A second strobe neither restarts nor delays the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to `clk` |
| tick | input | 1 | Timebase strobe, one pulse per TICK_NS |
| start | input | 1 | Request strobe, accepted only when idle |
| hblank | input | 1 | Horizontal blanking status, 1 while in blanking |
| sense | input | 1 | Raw comparator sense bit, active-low |
| result_o | output | READS (2) | Per-reading result; bit 0 is the first reading |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Timeout flag, valid with `done_o` |

## Verification
The assertions assume that `hblank`, `sense`, `start` and `tick` are already synchronous to `clk` and change only between rising edges. They also assume that `tick` is a one-cycle strobe. The bench drives every input half a clock after the rising edge, so each level is stable when the design samples it. It generates blanking as a fixed 20-cycle line, with 8 cycles in blanking. It starts each normal request at the same line phase, so read instants fall at known distances from the blanking edges. The sense patterns used are steady levels, a per-clock toggle, a step within the line and a line-parity pattern. They are chosen so that each expected result follows from the requirements alone.

// File: rtl/hss_pkg.sv
package hss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_OUT,
        ST_WAIT_IN,
        ST_WAIT_EXIT,
        ST_SETTLE,
        ST_CONFIRM,
        ST_RECHECK
    } hss_state_e;

endpackage

// File: rtl/hss_tick_timer.sv
module hss_tick_timer #(
    parameter int unsigned LIMIT = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign expire = tick && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R7: without a tick the count is frozen
    p_hold_without_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q));

    // R6: the count never passes the terminal value
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

endmodule

// File: rtl/hss_attempt_ctr.sv
module hss_attempt_ctr #(
    parameter int unsigned MAX = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int unsigned AW = (MAX > 1) ? $clog2(MAX + 1) : 1;
    localparam logic [AW-1:0] FINAL = AW'(MAX - 1);

    logic [AW-1:0] cnt_d, cnt_q;

    assign last = (cnt_q == FINAL);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && !last) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R5: failed attempts never exceed the limit
    p_attempt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FINAL);

endmodule

// File: rtl/hblank_sense_sampler.sv
module hblank_sense_sampler
    import hss_pkg::*;
#(
    parameter int unsigned READS        = 2,
    parameter int unsigned TICK_NS      = 1000,
    parameter int unsigned TIMEOUT_NS   = 10_000_000,
    parameter int unsigned SETTLE_NS    = 100_000,
    parameter int unsigned MAX_ATTEMPTS = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             hblank,
    input  logic             sense,
    output logic [READS-1:0] result_o,
    output logic             done_o,
    output logic             err_o
);
    localparam int unsigned TIMEOUT_TICKS = (TIMEOUT_NS / TICK_NS > 0) ? TIMEOUT_NS / TICK_NS : 1;
    localparam int unsigned SETTLE_TICKS  = (SETTLE_NS / TICK_NS > 0) ? SETTLE_NS / TICK_NS : 1;
    localparam int unsigned IDX_W         = (READS > 1) ? $clog2(READS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(READS - 1);

    typedef struct packed {
        hss_state_e       st;
        logic [IDX_W-1:0] idx;
        logic             base;
        logic             conf;
        logic [READS-1:0] acc;
        logic [READS-1:0] res;
        logic             done;
        logic             err;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st:   ST_IDLE,
        idx:  '0,
        base: 1'b0,
        conf: 1'b0,
        acc:  '0,
        res:  '0,
        done: 1'b0,
        err:  1'b0
    };

    ctl_t d, q;
    logic to_exp, st_exp, att_last;
    logic restart, abort, fin, fin_val;

    hss_tick_timer #(.LIMIT(TIMEOUT_TICKS)) u_timeout (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .tick   (tick),
        .expire (to_exp)
    );

    hss_tick_timer #(.LIMIT(SETTLE_TICKS)) u_settle (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (restart),
        .tick   (tick),
        .expire (st_exp)
    );

    hss_attempt_ctr #(.MAX(MAX_ATTEMPTS)) u_attempts (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (q.st == ST_SETTLE),
        .inc   (q.st == ST_RECHECK),
        .last  (att_last)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        abort   = 1'b0;
        fin     = 1'b0;
        fin_val = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st  = ST_WAIT_OUT;
                    d.idx = '0;
                    d.acc = '0;
                    d.err = 1'b0;
                end
            end
            ST_WAIT_OUT: begin
                if (!hblank)     d.st  = ST_WAIT_IN;
                else if (to_exp) abort = 1'b1;
            end
            ST_WAIT_IN: begin
                if (hblank)      d.st  = ST_WAIT_EXIT;
                else if (to_exp) abort = 1'b1;
            end
            ST_WAIT_EXIT: begin
                if (!hblank)     d.st  = ST_SETTLE;
                else if (to_exp) abort = 1'b1;
            end
            ST_SETTLE: begin
                if (st_exp) begin
                    d.base = sense;
                    d.st   = ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (st_exp) begin
                    if (sense == q.base) begin
                        fin     = 1'b1;
                        fin_val = q.base;
                    end else begin
                        d.conf = sense;
                        d.st   = ST_RECHECK;
                    end
                end
            end
            ST_RECHECK: begin
                if (sense == q.conf) d.base = q.conf;
                if (att_last) begin
                    fin     = 1'b1;
                    fin_val = 1'b0;
                end else begin
                    d.st = ST_CONFIRM;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (abort) begin
            d.st   = ST_IDLE;
            d.done = 1'b1;
            d.err  = 1'b1;
            d.res  = '0;
        end

        if (fin) begin
            d.acc[q.idx] = fin_val;
            if (q.idx == LAST_IDX) begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                d.res  = d.acc;
            end else begin
                d.idx = q.idx + 1'b1;
                d.st  = ST_WAIT_OUT;
            end
        end
    end

    assign restart = (d.st != q.st) || (q.st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign result_o = q.res;
    assign done_o   = q.done;
    assign err_o    = q.err;

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: the result changes only together with completion
    p_result_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    // R6: the error flag rises only with completion
    p_err_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> done_o);

    // R6: an aborted request reports a cleared result
    p_err_clears_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (result_o == '0));

    // R9: a strobe during a request never rewinds the reading index
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE && start) |=> (q.st != ST_WAIT_OUT || q.idx != '0 || $past(q.st) == ST_WAIT_OUT));

endmodule

// File: tb/hblank_sense_sampler_tb.sv
`timescale 1ns/1ps
module hblank_sense_sampler_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       start = 1'b0;
    logic       hblank = 1'b1;
    logic       sense = 1'b0;
    logic [1:0] result_o;
    logic       done_o;
    logic       err_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int done_cnt = 0;
    int ph = 0;
    int lc = 0;
    int c = 0;
    bit tog = 1'b0;
    int hb_mode = 0;
    int sm = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    hblank_sense_sampler #(
        .READS        (2),
        .TICK_NS      (1),
        .TIMEOUT_NS   (40),
        .SETTLE_NS    (5),
        .MAX_ATTEMPTS (20)
    ) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .start    (start),
        .hblank   (hblank),
        .sense    (sense),
        .result_o (result_o),
        .done_o   (done_o),
        .err_o    (err_o)
    );

    // line generator: 20-cycle line, blanking during phases 0..7
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (done_o) done_cnt = done_cnt + 1;
        ph = (ph == 19) ? 0 : ph + 1;
        if (ph == 8) begin
            lc = lc + 1;
            c = 0;
        end else if (c < 255) begin
            c = c + 1;
        end
        tog = ~tog;
        case (hb_mode)
            0:       hblank = (ph < 8);
            1:       hblank = 1'b1;
            default: hblank = 1'b0;
        endcase
        case (sm)
            0:       sense = 1'b0;
            1:       sense = 1'b1;
            2:       sense = tog;
            3:       sense = (c >= 8);
            default: sense = (lc[0] == 1'b0);
        endcase
        if (cyc == 150000 && !finished) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    typedef struct packed {
        logic [1:0] hb;
        logic [2:0] sm;
        logic [1:0] res;
        logic       err;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 3'd0, 2'b00, 1'b0},
        '{2'd0, 3'd1, 2'b11, 1'b0},
        '{2'd0, 3'd4, 2'b01, 1'b0},
        '{2'd0, 3'd3, 2'b11, 1'b0},
        '{2'd0, 3'd2, 2'b00, 1'b0},
        '{2'd1, 3'd1, 2'b00, 1'b1},
        '{2'd2, 3'd1, 2'b00, 1'b1}
    };

    function automatic string vtag(int i);
        case (i)
            0, 1:    return "R3";
            2:       return "R2";
            3:       return "R4";
            4:       return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic start_req();
        if (hb_mode == 0) begin
            do begin
                @(negedge clk);
                #1;
            end while (!(ph == 1 && lc[0] == 1'b0));
        end else begin
            @(negedge clk);
            #1;
        end
        start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
    endtask

    task automatic wait_done(output bit seen);
        seen = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            if (done_o) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        bit seen;
        int t0;
        int lat;
        int lat_ref;
        int d0;
        lat_ref = 0;

        repeat (5) @(negedge clk);
        #1;
        // R1: reset values
        chk("R1 result after reset", 32'(result_o), 32'd0);
        chk("R1 done after reset", 32'(done_o), 32'd0);
        chk("R1 err after reset", 32'(err_o), 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            hb_mode = int'(VECS[i].hb);
            sm = int'(VECS[i].sm);
            repeat (25) @(negedge clk);
            start_req();
            t0 = cyc;
            wait_done(seen);
            lat = cyc - t0;
            if (i == 1) lat_ref = lat;
            chk({vtag(i), " done seen"}, 32'(seen), 32'd1);
            chk({vtag(i), " result"}, 32'(result_o), 32'(VECS[i].res));
            chk({vtag(i), " err"}, 32'(err_o), 32'(VECS[i].err));
            @(negedge clk);
            #1;
            chk("R8 done lasts one cycle", 32'(done_o), 32'd0);
        end

        // R7: no ticks, no timeout
        hb_mode = 1;
        sm = 1;
        tick = 1'b0;
        repeat (10) @(negedge clk);
        start_req();
        d0 = done_cnt;
        repeat (200) @(negedge clk);
        #1;
        chk("R7 no timeout without tick", 32'(done_cnt - d0), 32'd0);
        tick = 1'b1;
        wait_done(seen);
        chk("R7 timeout once ticks resume", 32'(seen && err_o), 32'd1);

        // R9: second strobe mid-request changes nothing
        hb_mode = 0;
        sm = 1;
        repeat (25) @(negedge clk);
        start_req();
        t0 = cyc;
        d0 = done_cnt;
        repeat (30) @(negedge clk);
        #1;
        start = 1'b1;
        @(negedge clk);
        #1;
        start = 1'b0;
        wait_done(seen);
        lat = cyc - t0;
        chk("R9 latency unchanged by extra strobe", 32'(lat), 32'(lat_ref));
        chk("R9 result", 32'(result_o), 32'b11);
        repeat (80) @(negedge clk);
        #1;
        chk("R9 single completion", 32'(done_cnt - d0), 32'd1);

        // R8: outputs held after completion
        chk("R8 result held", 32'(result_o), 32'b11);
        chk("R8 err held clear", 32'(err_o), 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule